// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with two independent outputs. One shared control word holds, for each channel, a clock-divider code, a run enable, the output level used during the active part of the period, a clock gate, two stored mode bits and a bypass bit. Channel 1's fields sit 15 bits above channel 0's. Each channel also has its own timing word, which holds a period length and an active (duty) count.

Each channel divides the core clock by a ratio picked from a sparse table. On every divided tick it advances a period counter. The output is at the active level while the counter is below the duty count, and at the opposite level for the rest of the period.

While a channel runs, a new timing word is held in a shadow copy. It takes effect only when the current period ends, and a per-channel ready flag in the control word shows that it is still pending. Software writes the timing word while the channel is stopped, then sets the enable and clock-gate bits to start the waveform.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset, the control word and both timing words read as zero, both ready flags read 0, and both outputs are high (the inactive level for active level 0).
- R2: The control word is at byte address 0x0 and channel n's timing word at 0x4+4n. Per channel, relative to a base of 15·n: bits [3:0] are the divider code, bit 4 enable, bit 5 active level, bit 6 clock gate, bits 7 and 8 stored mode bits, bit 9 bypass. The timing word holds period-minus-one P in bits [23:16] and duty D in bits [7:0], and reads back as written.
- R3: Control bits 28+n are the read-only ready flags. Writes to them are ignored, and every other control bit reads back as written.
- R4: Divider codes 0..4 give ratios 120, 180, 240, 360, 480; codes 8..12 give 12000, 24000, 36000, 48000, 72000; code 15 gives 1. Counting k from the enabling edge, the period counter holds floor(k/ratio) mod (P+1).
- R5: A period lasts P+1 divided ticks. The output is active while counter < D, so D ≥ P+1 gives a fully active period and D = 0 a fully inactive one.
- R6: The active-level bit gives the output level while counter < D; the output takes the opposite level otherwise.
- R7: A channel runs only while both enable and clock gate are 1. Otherwise its output is inactive and its counters restart from zero.
- R8: Unused codes (5, 6, 7, 13, 14) stop the divided tick, and the output holds the inactive level.
- R9: A timing write to a running channel sets its ready flag at once. The new values are loaded only at the tick that ends the current period, and the flag clears then.
- R10: Stopping a channel clears its ready flag at once and loads the pending timing word. A timing write to a stopped channel takes effect directly.
- R11: With bypass set on a running channel with a valid code, the output follows the raw core clock.
- R12: The two mode bits have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bus_we_i | input | 1 | write strobe, one word per cycle |
| bus_addr_i | input | 4 | byte address |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data, combinational from address |
| pwm_o | output | 2 | channel outputs |

## Verification
Register readback, including the ready flags, is combinational. The bench reads it in the low phase right after the write edge, and at that point a ready flag raised by a running-channel write is already set. The output waveform is measured from the enabling write edge: after k further rising edges the counter holds floor(k/ratio) mod (P+1), and the bench compares the output at each falling edge against that count. A deferred timing update appears at exactly the edge that closes the current period, and the ready flag falls at that same edge. Bypass is the only result that depends on clock phase, so it is sampled once in the high phase and once in the low phase.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int CODE_W = 4;
  localparam int PRE_W  = 17;
  localparam int F_CODE = 0;
  localparam int F_EN   = 4;
  localparam int F_ACT  = 5;
  localparam int F_GATE = 6;
  localparam int F_BYP  = 9;

  // 0 marks an unused code
  function automatic logic [PRE_W-1:0] div_ratio(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:    return PRE_W'(120);
      4'd1:    return PRE_W'(180);
      4'd2:    return PRE_W'(240);
      4'd3:    return PRE_W'(360);
      4'd4:    return PRE_W'(480);
      4'd8:    return PRE_W'(12000);
      4'd9:    return PRE_W'(24000);
      4'd10:   return PRE_W'(36000);
      4'd11:   return PRE_W'(48000);
      4'd12:   return PRE_W'(72000);
      4'd15:   return PRE_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              valid_o
);
  logic [PRE_W-1:0] ratio, pre_q;

  assign ratio   = div_ratio(code_i);
  assign valid_o = (ratio != '0);
  assign tick_o  = run_i && valid_o && (pre_q == ratio - PRE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (!run_i || !valid_o)  pre_q <= '0;
    else if (tick_o)              pre_q <= '0;
    else                          pre_q <= pre_q + PRE_W'(1);
  end

  // R4
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && valid_o) |-> (pre_q < ratio));
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  input  logic              gate_i,
  input  logic              act_i,
  input  logic              bypass_i,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  prd_i,
  input  logic [CNT_W-1:0]  duty_i,
  output logic [CNT_W-1:0]  sh_prd_o,
  output logic [CNT_W-1:0]  sh_duty_o,
  output logic              ready_o,
  output logic              pwm_o
);
  logic run, tick, code_ok, wave, wrap;
  logic [CNT_W-1:0] sh_prd_q, sh_duty_q, prd_q, duty_q, cnt_q;
  logic pending_q;

  assign run = en_i & gate_i;

  pwm2_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .code_i  (code_i),
    .tick_o  (tick),
    .valid_o (code_ok)
  );

  assign wrap = (cnt_q == prd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_prd_q  <= '0;
      sh_duty_q <= '0;
      prd_q     <= '0;
      duty_q    <= '0;
      cnt_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      if (per_we_i) begin
        sh_prd_q  <= prd_i;
        sh_duty_q <= duty_i;
      end
      if (!run) begin
        cnt_q     <= '0;
        pending_q <= 1'b0;
        prd_q     <= per_we_i ? prd_i  : sh_prd_q;
        duty_q    <= per_we_i ? duty_i : sh_duty_q;
      end else begin
        if (tick) begin
          if (wrap) begin
            cnt_q <= '0;
            if (pending_q) begin
              prd_q     <= sh_prd_q;
              duty_q    <= sh_duty_q;
              pending_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        // a write in the wrap cycle stays pending for the next period
        if (per_we_i) pending_q <= 1'b1;
      end
    end
  end

  assign wave      = (cnt_q < duty_q);
  assign sh_prd_o  = sh_prd_q;
  assign sh_duty_o = sh_duty_q;
  assign ready_o   = pending_q & run;
  assign pwm_o     = (run && code_ok) ? (bypass_i ? clk_i : (wave ? act_i : ~act_i))
                                      : ~act_i;

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_q <= prd_q));
  // R9
  period_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && (prd_q != $past(prd_q))) |-> (cnt_q == '0));
  // R10
  ready_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !pending_q);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run && !code_ok) |-> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int CH_STRIDE = 15,
  parameter int RDY_BASE  = 28,
  parameter int PRD_LSB   = 16,
  parameter int PER_BASE  = 4,
  parameter int PER_STEP  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  localparam logic [31:0] RDY_MASK = ((32'd1 << NCH) - 32'd1) << RDY_BASE;

  logic [31:0]      ctrl_q;
  logic [NCH-1:0]   ready;
  logic [CNT_W-1:0] sh_prd  [NCH];
  logic [CNT_W-1:0] sh_duty [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (bus_we_i && bus_addr_i == '0)      ctrl_q <= bus_wdata_i & ~RDY_MASK;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int B = n * CH_STRIDE;
    localparam logic [ADDR_W-1:0] A = ADDR_W'(PER_BASE + PER_STEP * n);
    logic per_we;
    assign per_we = bus_we_i && (bus_addr_i == A);

    pwm2_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (ctrl_q[B+F_CODE +: CODE_W]),
      .en_i      (ctrl_q[B+F_EN]),
      .gate_i    (ctrl_q[B+F_GATE]),
      .act_i     (ctrl_q[B+F_ACT]),
      .bypass_i  (ctrl_q[B+F_BYP]),
      .per_we_i  (per_we),
      .prd_i     (bus_wdata_i[PRD_LSB +: CNT_W]),
      .duty_i    (bus_wdata_i[CNT_W-1:0]),
      .sh_prd_o  (sh_prd[n]),
      .sh_duty_o (sh_duty[n]),
      .ready_o   (ready[n]),
      .pwm_o     (pwm_o[n])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == '0)
      bus_rdata_o = ctrl_q | ({{(32-NCH){1'b0}}, ready} << RDY_BASE);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr_i == ADDR_W'(PER_BASE + PER_STEP * n)) begin
        bus_rdata_o[PRD_LSB +: CNT_W] = sh_prd[n];
        bus_rdata_o[CNT_W-1:0]        = sh_duty[n];
      end
    end
  end

  // R3
  rdy_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & RDY_MASK) == '0);
endmodule

// File: tb/pwm2_ctrl_test.sv
`timescale 1ns/1ps
module pwm2_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pwm2_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int ratio_of(input int code);
    case (code)
      0: return 120;   1: return 180;   2: return 240;   3: return 360;   4: return 480;
      8: return 12000; 9: return 24000; 10: return 36000; 11: return 48000; 12: return 72000;
      15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_wave(input int k, input int r, input int p, input int d, input logic act);
    int c;
    c = (k / r) % (p + 1);
    return (c < d) ? act : ~act;
  endfunction

  function automatic logic [31:0] cw(input int ch, input int code, input bit en, input bit gate,
                                     input bit act, input bit byp, input bit mode, input bit pulse);
    logic [31:0] f;
    f = 32'(code & 15) | (32'(en) << 4) | (32'(act) << 5) | (32'(gate) << 6)
      | (32'(mode) << 7) | (32'(pulse) << 8) | (32'(byp) << 9);
    return f << (15 * ch);
  endfunction

  function automatic logic [31:0] pw(input int p, input int d);
    return (32'(p & 255) << 16) | 32'(d & 255);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // checks pwm[ch] from phase k0 for n cycles, one per falling edge
  task automatic run_wave(input int ch, input int r, input int p, input int d, input logic act,
                          input int k0, input int n, input string req);
    for (int k = k0; k < k0 + n; k++) begin
      chk(req, 32'(pwm[ch]), 32'(exp_wave(k, r, p, d, act)));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h4, v); chk("R1 timing0", v, 32'h0);
    rd(4'h8, v); chk("R1 timing1", v, 32'h0);
    chk("R1 outputs", 32'(pwm), 32'h3);
    @(negedge clk);

    // R2 map and readback
    wr(4'h4, pw(8'h12, 8'h34));
    rd(4'h4, v); chk("R2 timing0 readback", v, 32'h0012_0034);
    @(negedge clk);
    wr(4'h8, pw(1, 1));
    wr(4'h0, cw(1, 15, 1, 1, 1, 0, 0, 0));
    rd(4'h0, v); chk("R2 ctrl readback ch1", v, cw(1, 15, 1, 1, 1, 0, 0, 0));
    @(negedge clk);
    wr(4'h0, 32'h0);
    wr(4'h0, cw(1, 15, 1, 1, 1, 0, 0, 0));
    for (int k = 0; k < 8; k++) begin
      chk("R2 ch1 wave", 32'(pwm[1]), 32'(exp_wave(k, 1, 1, 1, 1'b1)));
      chk("R2 ch0 idle", 32'(pwm[0]), 32'h1);
      @(negedge clk);
    end
    wr(4'h0, 32'h0);

    // R3 ready bits read-only
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R3 ready bits ignored", v, 32'hCFFF_FFFF);
    @(negedge clk);
    wr(4'h0, 32'h0);

    // R5 directed: zero duty and full duty
    wr(4'h4, pw(3, 0));
    wr(4'h0, cw(0, 15, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 3, 0, 1'b1, 0, 10, "R5 duty zero");
    wr(4'h0, 32'h0);
    wr(4'h4, pw(3, 4));
    wr(4'h0, cw(0, 15, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 3, 4, 1'b1, 0, 10, "R5 duty full");
    wr(4'h0, 32'h0);

    // R12 mode bits ignored
    wr(4'h4, pw(4, 2));
    wr(4'h0, cw(0, 15, 1, 1, 0, 0, 1, 1));
    run_wave(0, 1, 4, 2, 1'b0, 0, 12, "R12 mode bits");
    wr(4'h0, 32'h0);

    // R4 large ratio boundary
    wr(4'h4, pw(1, 1));
    wr(4'h0, cw(0, 8, 1, 1, 1, 0, 0, 0));
    for (int k = 0; k < 12002; k++) begin
      if (k == 0 || k == 11999 || k == 12000 || k == 12001)
        chk("R4 ratio 12000", 32'(pwm[0]), 32'(exp_wave(k, 12000, 1, 1, 1'b1)));
      @(negedge clk);
    end
    wr(4'h0, 32'h0);

    // R4 R5 R6 random trials
    for (int t = 0; t < 10; t++) begin
      int codes[4] = '{15, 0, 1, 2};
      int ch, code, p, d, r;
      bit act;
      ch   = int'($urandom % 2);
      code = codes[$urandom % 4];
      p    = int'($urandom % 4);
      d    = int'($urandom % (p + 3));
      act  = 1'($urandom % 2);
      r    = ratio_of(code);
      wr(4'h0, 32'h0);
      wr(ch == 0 ? 4'h4 : 4'h8, pw(p, d));
      wr(4'h0, cw(ch, code, 1, 1, act, 0, 0, 0));
      run_wave(ch, r, p, d, act, 0, 2 * (p + 1) * r + 3, "R4 R5 R6 random");
    end
    wr(4'h0, 32'h0);

    // R7 both enable and gate required
    wr(4'h4, pw(3, 2));
    wr(4'h0, cw(0, 15, 1, 0, 1, 0, 0, 0));
    run_wave(0, 1, 0, 0, 1'b1, 0, 6, "R7 gate off");
    wr(4'h0, cw(0, 15, 0, 1, 1, 0, 0, 0));
    run_wave(0, 1, 0, 0, 1'b1, 0, 6, "R7 enable off");
    wr(4'h0, cw(0, 15, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 3, 2, 1'b1, 0, 9, "R7 restart");
    wr(4'h0, 32'h0);

    // R8 unused codes
    wr(4'h0, cw(0, 5, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 0, 0, 1'b1, 0, 20, "R8 code 5");
    wr(4'h0, cw(0, 14, 1, 1, 0, 0, 0, 0));
    run_wave(0, 1, 0, 0, 1'b0, 0, 20, "R8 code 14");
    wr(4'h0, 32'h0);

    // R9 deferred update
    wr(4'h4, pw(3, 1));
    wr(4'h0, cw(0, 15, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 3, 1, 1'b1, 0, 4, "R9 old wave");
    chk("R9 old wave", 32'(pwm[0]), 32'(exp_wave(4, 1, 3, 1, 1'b1)));
    wr(4'h4, pw(5, 4));
    for (int k = 5; k < 8; k++) begin
      rd(4'h0, v); chk("R9 ready set", 32'(v[28]), 32'h1);
      chk("R9 old kept", 32'(pwm[0]), 32'(exp_wave(k, 1, 3, 1, 1'b1)));
      @(negedge clk);
    end
    rd(4'h0, v); chk("R9 ready clear at wrap", 32'(v[28]), 32'h0);
    run_wave(0, 1, 5, 4, 1'b1, 0, 12, "R9 new wave");

    // R10 stop clears ready, loads pending
    wr(4'h4, pw(2, 1));
    rd(4'h0, v); chk("R10 ready before stop", 32'(v[28]), 32'h1);
    @(negedge clk);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R10 ready after stop", 32'(v[28]), 32'h0);
    @(negedge clk);
    wr(4'h0, cw(0, 15, 1, 1, 1, 0, 0, 0));
    run_wave(0, 1, 2, 1, 1'b1, 0, 9, "R10 pending loaded");
    wr(4'h0, 32'h0);

    // R11 bypass
    wr(4'h0, cw(0, 15, 1, 1, 0, 1, 0, 0));
    for (int k = 0; k < 3; k++) begin
      chk("R11 bypass low phase", 32'(pwm[0]), 32'h0);
      @(posedge clk); #1;
      chk("R11 bypass high phase", 32'(pwm[0]), 32'h1);
      @(negedge clk);
    end
    wr(4'h0, cw(0, 6, 1, 1, 0, 1, 0, 0));
    @(posedge clk); #1;
    chk("R8 R11 bypass with unused code", 32'(pwm[0]), 32'h1);
    @(negedge clk);
    wr(4'h0, 32'h0);

    finish_run();
  end
endmodule